// File: doc/BRIEF.md
# PC Keyboard Controller Host Interface

This block is the host-facing register front of a two-channel keyboard/auxiliary controller. The host sees one byte-wide port with a single address bit, `host_sel`. With `host_sel` low it reaches the data port. With `host_sel` high it reaches the command/status port. Reading the command port returns a live status byte. Writing it issues a controller command. Some commands return a reply byte. Others change the mode register or the output-port register. A set of commands arms a one-shot steering latch, so that the next data-port write goes to an internal target and not to the keyboard device.

Each device side has a one-byte holding register. It is filled either from the device through a ready/valid input or from the controller itself. The controller fills it with command replies and with bytes the host injects. A data-port read pops one of the two holding registers. The keyboard side takes precedence unless only the auxiliary side holds a byte. Two interrupt lines, the status flags and the output-port view are all derived from the holding-register state and the mode byte. The block also drives an A20 gate line and a one-cycle system-reset request. It does not model the serial device protocol or scan-code translation.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, the output port reads back as 0xCF, `a20_gate` is 1 and both interrupts are 0.
- R2: The status byte is built as follows. Bit 0 is set when either holding register is full. Bit 2 is the self-test flag. Bit 3 is 1 after a command-port write and 0 after a data-port write. Bit 4 is always 1. Bit 5 is set when only the aux holding register is full. Bits 1, 6 and 7 are 0.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm a latch. The next data-port write then goes to one target, in that order: the mode byte, the output port, the keyboard holding register, the aux holding register, or `aux_tx` for one cycle. After that write the latch returns to idle.
- R4: A data-port write with no latch armed appears on `kbd_tx_valid`/`kbd_tx_data` in the same cycle. It changes no register.
- R5: Several commands place a reply in the keyboard holding register. 0x20 replies with the mode byte. 0xD0 replies with the output-port view, whose bits 4 and 5 are the live "any full" and "aux only" flags. 0xA9 and 0xAB reply 0x00. 0xC0 replies 0x80. 0xAA sets status bit 2 and replies 0x55.
- R6: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it. The interrupt outputs follow in the next cycle.
- R7: A command whose upper nibble is 0xF requests a system reset when its bit 0 is 0, and has no effect otherwise. A reset request is a one-cycle pulse on `sys_reset_req` in the cycle after the write.
- R8: Command 0xDF sets output-port bit 1 and raises `a20_gate`. Command 0xDD clears that bit and lowers `a20_gate`.
- R9: A data write steered to the output port stores the byte. `a20_gate` then follows bit 1 of that byte. If bit 0 of the byte is 0, a one-cycle reset request is issued.
- R10: `irq_aux` is 1 when only the aux register is full and mode bit 1 is set. `irq_kbd` is 1 when the keyboard register is full, mode bit 0 is set and mode bit 4 is clear.
- R11: A data-port read returns the aux byte and empties the aux register only when the aux register alone is full. Otherwise it returns the keyboard byte and empties the keyboard register.
- R12: A device input is ready only while its holding register is empty and no internal byte is being loaded into it in that cycle. An internal load has priority over the device byte.
- R13: A command code not listed above changes no register and does not disturb an armed latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; a data-port read pops a byte |
| host_sel | input | 1 | 0 = data port, 1 = command/status port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or selected holding byte |
| kbd_in_valid | input | 1 | Keyboard device byte offered |
| kbd_in_data | input | 8 | Keyboard device byte |
| kbd_in_ready | output | 1 | Keyboard holding register can accept |
| aux_in_valid | input | 1 | Aux device byte offered |
| aux_in_data | input | 8 | Aux device byte |
| aux_in_ready | output | 1 | Aux holding register can accept |
| kbd_tx_valid | output | 1 | Byte forwarded to the keyboard device |
| kbd_tx_data | output | 8 | Forwarded keyboard byte |
| aux_tx_valid | output | 1 | Byte forwarded to the aux device |
| aux_tx_data | output | 8 | Forwarded aux byte |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Aux interrupt level |
| a20_gate | output | 1 | A20 gate level, output-port bit 1 |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
Most internal errors in this block show up at the ports within one cycle. The status byte, the interrupt levels, the ready outputs and the choice of read byte are all formed directly from the holding-register flags and the mode byte. A wrong flag, a wrong mode bit or a wrong arbitration choice is therefore visible on the next status read or interrupt sample. A corrupted steering latch stays hidden until the following data-port write. At that point the byte appears on the wrong transmit output or lands in the wrong register. Reply and readback commands then expose that register.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

   localparam int NSRC    = 2;
   localparam int SRC_KBD = 0;
   localparam int SRC_AUX = 1;

   // mode byte bit positions
   localparam int MB_KBD_IRQ = 0;
   localparam int MB_AUX_IRQ = 1;
   localparam int MB_KBD_DIS = 4;
   localparam int MB_AUX_DIS = 5;

   // output port bit positions
   localparam int OP_RUN = 0;
   localparam int OP_A20 = 1;

   // command codes
   localparam logic [7:0] C_GET_MODE  = 8'h20;
   localparam logic [7:0] C_SET_MODE  = 8'h60;
   localparam logic [7:0] C_AUX_OFF   = 8'hA7;
   localparam logic [7:0] C_AUX_ON    = 8'hA8;
   localparam logic [7:0] C_AUX_TEST  = 8'hA9;
   localparam logic [7:0] C_SELFTEST  = 8'hAA;
   localparam logic [7:0] C_KBD_TEST  = 8'hAB;
   localparam logic [7:0] C_KBD_OFF   = 8'hAD;
   localparam logic [7:0] C_KBD_ON    = 8'hAE;
   localparam logic [7:0] C_GET_IN    = 8'hC0;
   localparam logic [7:0] C_GET_OUT   = 8'hD0;
   localparam logic [7:0] C_SET_OUT   = 8'hD1;
   localparam logic [7:0] C_PUT_KBUF  = 8'hD2;
   localparam logic [7:0] C_PUT_ABUF  = 8'hD3;
   localparam logic [7:0] C_TO_AUX    = 8'hD4;
   localparam logic [7:0] C_GATE_LO   = 8'hDD;
   localparam logic [7:0] C_GATE_HI   = 8'hDF;

   typedef enum logic [2:0] {
      TGT_NONE, TGT_MODE, TGT_OUTP, TGT_KBUF, TGT_ABUF, TGT_AUXDEV
   } tgt_e;

   typedef enum logic [2:0] {
      RPL_NONE, RPL_MODE, RPL_OUTP, RPL_ZERO, RPL_INPORT, RPL_SELFTEST
   } rpl_e;

   typedef struct packed {
      logic arm;
      tgt_e tgt;
      rpl_e rpl;
      logic aux_off;
      logic aux_on;
      logic kbd_off;
      logic kbd_on;
      logic gate_hi;
      logic gate_lo;
      logic sys_rst;
   } act_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
   import kbc_pkg::*;
(
   input  logic [7:0] cmd,
   output act_t       act
);

   always_comb begin
      act = '0;
      act.tgt = TGT_NONE;
      act.rpl = RPL_NONE;
      if (cmd[7:4] == 4'hF) begin
         act.sys_rst = ~cmd[0];
      end else begin
         unique case (cmd)
            C_GET_MODE: act.rpl = RPL_MODE;
            C_GET_OUT:  act.rpl = RPL_OUTP;
            C_AUX_TEST: act.rpl = RPL_ZERO;
            C_KBD_TEST: act.rpl = RPL_ZERO;
            C_GET_IN:   act.rpl = RPL_INPORT;
            C_SELFTEST: act.rpl = RPL_SELFTEST;
            C_SET_MODE: begin act.arm = 1'b1; act.tgt = TGT_MODE;   end
            C_SET_OUT:  begin act.arm = 1'b1; act.tgt = TGT_OUTP;   end
            C_PUT_KBUF: begin act.arm = 1'b1; act.tgt = TGT_KBUF;   end
            C_PUT_ABUF: begin act.arm = 1'b1; act.tgt = TGT_ABUF;   end
            C_TO_AUX:   begin act.arm = 1'b1; act.tgt = TGT_AUXDEV; end
            C_AUX_OFF:  act.aux_off = 1'b1;
            C_AUX_ON:   act.aux_on  = 1'b1;
            C_KBD_OFF:  act.kbd_off = 1'b1;
            C_KBD_ON:   act.kbd_on  = 1'b1;
            C_GATE_HI:  act.gate_hi = 1'b1;
            C_GATE_LO:  act.gate_lo = 1'b1;
            default:    act = act;
         endcase
      end
   end

endmodule

// File: rtl/kbc_src_buf.sv
module kbc_src_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_valid,
   input  logic [DATA_W-1:0] dev_data,
   output logic              dev_ready,
   input  logic              inj_valid,
   input  logic [DATA_W-1:0] inj_data,
   input  logic              pop,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   assign dev_ready = ~full_q & ~inj_valid;
   assign full      = full_q;
   assign data      = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (inj_valid) begin
         full_q <= 1'b1;
         data_q <= inj_data;
      end else if (dev_valid && dev_ready) begin
         full_q <= 1'b1;
         data_q <= dev_data;
      end else if (pop) begin
         full_q <= 1'b0;
      end
   end

   AST_READY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ready |-> !full_q); // R12
   AST_INJECT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      inj_valid |=> (full_q && data_q == $past(inj_data))); // R12

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
   import kbc_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter logic [DATA_W-1:0] MODE_INIT   = 8'h03,
   parameter logic [DATA_W-1:0] OUTP_INIT   = 8'hCF,
   parameter logic [DATA_W-1:0] PASS_BYTE   = 8'h55,
   parameter logic [DATA_W-1:0] INPORT_BYTE = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              kbd_in_valid,
   input  logic [DATA_W-1:0] kbd_in_data,
   output logic              kbd_in_ready,
   input  logic              aux_in_valid,
   input  logic [DATA_W-1:0] aux_in_data,
   output logic              aux_in_ready,
   output logic              kbd_tx_valid,
   output logic [DATA_W-1:0] kbd_tx_data,
   output logic              aux_tx_valid,
   output logic [DATA_W-1:0] aux_tx_data,
   output logic              irq_kbd,
   output logic              irq_aux,
   output logic              a20_gate,
   output logic              sys_reset_req
);

   if (DATA_W != 8) begin : g_bad_width
      $error("kbc_host_if: command decode requires DATA_W == 8");
   end

   logic [DATA_W-1:0] mode_q;
   logic [1:0]        outp_hi_q;
   logic [3:0]        outp_lo_q;
   logic              selftest_q, cmdlast_q, rstp_q;
   tgt_e              latch_q;

   logic cmd_wr, dat_wr, rd_data;
   act_t act;

   logic [NSRC-1:0]             s_dev_valid, s_dev_ready, s_inj, s_pop, s_full;
   logic [NSRC-1:0][DATA_W-1:0] s_dev_data, s_inj_data, s_data;

   logic              any_full, aux_only;
   logic [DATA_W-1:0] outp_view, status_byte, reply_byte;

   assign cmd_wr  = host_wr & host_sel;
   assign dat_wr  = host_wr & ~host_sel;
   assign rd_data = host_rd & ~host_sel;

   kbc_cmd_decode u_dec (
      .cmd (host_wdata),
      .act (act)
   );

   assign any_full  = |s_full;
   assign aux_only  = s_full[SRC_AUX] & ~s_full[SRC_KBD];
   assign outp_view = {outp_hi_q, aux_only, any_full, outp_lo_q};
   assign status_byte = {2'b00, aux_only, 1'b1, cmdlast_q, selftest_q, 1'b0, any_full};

   always_comb begin
      unique case (act.rpl)
         RPL_MODE:     reply_byte = mode_q;
         RPL_OUTP:     reply_byte = outp_view;
         RPL_INPORT:   reply_byte = INPORT_BYTE;
         RPL_SELFTEST: reply_byte = PASS_BYTE;
         default:      reply_byte = '0;
      endcase
   end

   // source-side wiring
   assign s_dev_valid[SRC_KBD] = kbd_in_valid;
   assign s_dev_data[SRC_KBD]  = kbd_in_data;
   assign s_dev_valid[SRC_AUX] = aux_in_valid;
   assign s_dev_data[SRC_AUX]  = aux_in_data;

   assign s_inj[SRC_KBD] = (cmd_wr & (act.rpl != RPL_NONE)) |
                           (dat_wr & (latch_q == TGT_KBUF));
   assign s_inj_data[SRC_KBD] = cmd_wr ? reply_byte : host_wdata;
   assign s_inj[SRC_AUX]      = dat_wr & (latch_q == TGT_ABUF);
   assign s_inj_data[SRC_AUX] = host_wdata;

   assign s_pop[SRC_AUX] = rd_data & aux_only;
   assign s_pop[SRC_KBD] = rd_data & ~aux_only;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      kbc_src_buf #(.DATA_W(DATA_W)) u_buf (
         .clk       (clk),
         .rst_n     (rst_n),
         .dev_valid (s_dev_valid[i]),
         .dev_data  (s_dev_data[i]),
         .dev_ready (s_dev_ready[i]),
         .inj_valid (s_inj[i]),
         .inj_data  (s_inj_data[i]),
         .pop       (s_pop[i]),
         .full      (s_full[i]),
         .data      (s_data[i])
      );
   end

   assign kbd_in_ready = s_dev_ready[SRC_KBD];
   assign aux_in_ready = s_dev_ready[SRC_AUX];

   assign host_rdata = host_sel ? status_byte :
                       (aux_only ? s_data[SRC_AUX] : s_data[SRC_KBD]);

   assign kbd_tx_valid = dat_wr & (latch_q == TGT_NONE);
   assign kbd_tx_data  = host_wdata;
   assign aux_tx_valid = dat_wr & (latch_q == TGT_AUXDEV);
   assign aux_tx_data  = host_wdata;

   assign irq_aux = aux_only & mode_q[MB_AUX_IRQ];
   assign irq_kbd = s_full[SRC_KBD] & mode_q[MB_KBD_IRQ] & ~mode_q[MB_KBD_DIS];
   assign a20_gate      = outp_lo_q[OP_A20];
   assign sys_reset_req = rstp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_INIT;
         outp_hi_q  <= OUTP_INIT[7:6];
         outp_lo_q  <= OUTP_INIT[3:0];
         selftest_q <= 1'b0;
         cmdlast_q  <= 1'b1;
         rstp_q     <= 1'b0;
         latch_q    <= TGT_NONE;
      end else begin
         rstp_q <= 1'b0;
         if (cmd_wr) begin
            cmdlast_q <= 1'b1;
            if (act.arm)                  latch_q <= act.tgt;
            if (act.aux_off)              mode_q[MB_AUX_DIS] <= 1'b1;
            if (act.aux_on)               mode_q[MB_AUX_DIS] <= 1'b0;
            if (act.kbd_off)              mode_q[MB_KBD_DIS] <= 1'b1;
            if (act.kbd_on)               mode_q[MB_KBD_DIS] <= 1'b0;
            if (act.gate_hi)              outp_lo_q[OP_A20] <= 1'b1;
            if (act.gate_lo)              outp_lo_q[OP_A20] <= 1'b0;
            if (act.rpl == RPL_SELFTEST)  selftest_q <= 1'b1;
            rstp_q <= act.sys_rst;
         end else if (dat_wr) begin
            cmdlast_q <= 1'b0;
            latch_q   <= TGT_NONE;
            if (latch_q == TGT_MODE) mode_q <= host_wdata;
            if (latch_q == TGT_OUTP) begin
               outp_hi_q <= host_wdata[7:6];
               outp_lo_q <= host_wdata[3:0];
               rstp_q    <= ~host_wdata[OP_RUN];
            end
         end
      end
   end

   AST_LATCH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr |=> latch_q == TGT_NONE); // R3
   AST_RESET_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> $past(host_wr)); // R7
   AST_GATE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && host_wdata == C_GATE_HI) |=> a20_gate); // R8
   AST_GATE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && host_wdata == C_GATE_LO) |=> !a20_gate); // R8
   AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_kbd && irq_aux)); // R10
   AST_AUX_HELD_BEHIND_KBD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && s_full[SRC_KBD] && s_full[SRC_AUX]) |=> s_full[SRC_AUX]); // R11
   AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      selftest_q |=> selftest_q); // R5

endmodule

// File: tb/sim_kbc_host_if.sv
module sim_kbc_host_if;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr = 0, host_rd = 0, host_sel = 1;
   logic [7:0] host_wdata = 0;
   logic [7:0] host_rdata;
   logic kbd_in_valid = 0, aux_in_valid = 0;
   logic [7:0] kbd_in_data = 0, aux_in_data = 0;
   logic kbd_in_ready, aux_in_ready, kbd_tx_valid, aux_tx_valid;
   logic [7:0] kbd_tx_data, aux_tx_data;
   logic irq_kbd, irq_aux, a20_gate, sys_reset_req;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   kbc_host_if u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .kbd_in_valid(kbd_in_valid), .kbd_in_data(kbd_in_data), .kbd_in_ready(kbd_in_ready),
      .aux_in_valid(aux_in_valid), .aux_in_data(aux_in_data), .aux_in_ready(aux_in_ready),
      .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
      .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
      .irq_kbd(irq_kbd), .irq_aux(irq_aux), .a20_gate(a20_gate),
      .sys_reset_req(sys_reset_req)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_mode, m_outp, m_kb, m_ab;
   bit m_kv, m_av, m_st, m_cl, m_rp;
   int m_lat; // 0 idle, 1 mode, 2 outport, 3 kbd buffer, 4 aux buffer, 5 aux device

   function automatic bit has_reply(input logic [7:0] c);
      return (c == 8'h20) || (c == 8'hD0) || (c == 8'hA9) || (c == 8'hAB) ||
             (c == 8'hC0) || (c == 8'hAA);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 8'h03; m_outp = 8'hCF; m_kb = 0; m_ab = 0;
         m_kv = 0; m_av = 0; m_st = 0; m_cl = 1; m_rp = 0; m_lat = 0;
      end else begin
         automatic bit okv = m_kv, oav = m_av;
         automatic bit ao = m_av && !m_kv;
         automatic bit kinj = 0, ainj = 0, rp = 0;
         automatic logic [7:0] kval = 0, c = host_wdata;
         automatic logic [7:0] ov = {m_outp[7:6], ao, m_kv | m_av, m_outp[3:0]};
         if (host_wr && host_sel) begin
            m_cl = 1;
            if (c[7:4] == 4'hF) c = c[0] ? 8'hFF : 8'hFE;
            case (c)
               8'h20: begin kinj = 1; kval = m_mode; end
               8'hD0: begin kinj = 1; kval = ov; end
               8'hA9, 8'hAB: begin kinj = 1; kval = 8'h00; end
               8'hC0: begin kinj = 1; kval = 8'h80; end
               8'hAA: begin kinj = 1; kval = 8'h55; m_st = 1; end
               8'h60: m_lat = 1;
               8'hD1: m_lat = 2;
               8'hD2: m_lat = 3;
               8'hD3: m_lat = 4;
               8'hD4: m_lat = 5;
               8'hA7: m_mode[5] = 1;
               8'hA8: m_mode[5] = 0;
               8'hAD: m_mode[4] = 1;
               8'hAE: m_mode[4] = 0;
               8'hDF: m_outp[1] = 1;
               8'hDD: m_outp[1] = 0;
               8'hFE: rp = 1;
               default: ;
            endcase
         end else if (host_wr) begin
            m_cl = 0;
            case (m_lat)
               1: m_mode = host_wdata;
               2: begin m_outp = host_wdata; rp = !host_wdata[0]; end
               3: begin kinj = 1; kval = host_wdata; end
               4: ainj = 1;
               default: ;
            endcase
            m_lat = 0;
         end
         if (host_rd && !host_sel) begin
            if (ao) m_av = 0; else m_kv = 0;
         end
         if (kinj) begin m_kv = 1; m_kb = kval; end
         else if (kbd_in_valid && !okv) begin m_kv = 1; m_kb = kbd_in_data; end
         if (ainj) begin m_av = 1; m_ab = host_wdata; end
         else if (aux_in_valid && !oav) begin m_av = 1; m_ab = aux_in_data; end
         m_rp = rp;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         automatic bit ao = m_av && !m_kv;
         automatic bit dw = host_wr && !host_sel;
         automatic bit kinj_now = (host_wr && host_sel && has_reply(host_wdata)) ||
                                  (dw && m_lat == 3);
         automatic logic [7:0] st = {2'b00, ao, 1'b1, m_cl, m_st, 1'b0, m_kv || m_av};
         if (host_sel) chk("R2 status byte", host_rdata, st);
         else          chk("R11 read byte", host_rdata, ao ? m_ab : m_kb);
         chk("R10 irq_kbd", irq_kbd, m_kv && m_mode[0] && !m_mode[4]);
         chk("R10 irq_aux", irq_aux, ao && m_mode[1]);
         chk("R8 a20_gate", a20_gate, m_outp[1]);
         chk("R7 sys_reset_req", sys_reset_req, m_rp);
         chk("R12 kbd_in_ready", kbd_in_ready, !m_kv && !kinj_now);
         chk("R12 aux_in_ready", aux_in_ready, !m_av && !(dw && m_lat == 4));
         chk("R4 kbd_tx_valid", kbd_tx_valid, dw && m_lat == 0);
         chk("R3 aux_tx_valid", aux_tx_valid, dw && m_lat == 5);
         if (kbd_tx_valid) chk("R4 kbd_tx_data", kbd_tx_data, host_wdata);
         if (aux_tx_valid) chk("R3 aux_tx_data", aux_tx_data, host_wdata);
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic cmd(input logic [7:0] b);
      @(posedge clk); #2;
      host_wr = 1; host_sel = 1; host_wdata = b;
      @(posedge clk); #2;
      host_wr = 0; host_sel = 1;
   endtask

   task automatic dwr(input logic [7:0] b, input bit ek, input bit ea, input string tag);
      @(posedge clk); #2;
      host_wr = 1; host_sel = 0; host_wdata = b;
      #1;
      chk({tag, " kbd_tx_valid"}, kbd_tx_valid, ek);
      chk({tag, " aux_tx_valid"}, aux_tx_valid, ea);
      @(posedge clk); #2;
      host_wr = 0; host_sel = 1;
   endtask

   task automatic rd(input logic [7:0] exp, input string tag);
      @(posedge clk); #2;
      host_rd = 1; host_sel = 0;
      #1;
      chk(tag, host_rdata, exp);
      @(posedge clk); #2;
      host_rd = 0; host_sel = 1;
   endtask

   task automatic status_is(input logic [7:0] exp, input string tag);
      host_sel = 1; #1;
      chk(tag, host_rdata, exp);
   endtask

   initial begin : watchdog
      wait (cycles > 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(posedge clk); #2;
      status_is(8'h18, "R1 status after reset");
      chk("R1 a20 after reset", a20_gate, 1'b1);
      chk("R1 irq after reset", {irq_kbd, irq_aux}, 8'h00);

      cmd(8'h20);
      status_is(8'h19, "R2 status with byte waiting");
      chk("R10 irq_kbd with reply", irq_kbd, 1'b1);
      rd(8'h03, "R1 mode after reset");
      cmd(8'hD0);
      rd(8'hCF, "R1 outport after reset");

      // both sources at once: keyboard wins
      @(posedge clk); #2;
      kbd_in_valid = 1; kbd_in_data = 8'h1C; aux_in_valid = 1; aux_in_data = 8'h33;
      @(posedge clk); #2;
      kbd_in_valid = 0; aux_in_valid = 0;
      chk("R10 irq_aux masked while kbd full", irq_aux, 1'b0);
      rd(8'h1C, "R11 kbd read first");
      status_is(8'h39, "R2 aux-only status");
      chk("R10 irq_aux aux only", irq_aux, 1'b1);
      rd(8'h33, "R11 aux read when alone");

      // steering latch
      cmd(8'hD2); dwr(8'h77, 0, 0, "R3 inject kbd");
      status_is(8'h11, "R2 cmd flag cleared by data write");
      rd(8'h77, "R3 kbd inject byte");
      cmd(8'hD3); dwr(8'h44, 0, 0, "R3 inject aux");
      chk("R3 irq_aux after aux inject", irq_aux, 1'b1);
      rd(8'h44, "R3 aux inject byte");
      cmd(8'hD4); dwr(8'h99, 0, 1, "R3 to aux device");
      dwr(8'h12, 1, 0, "R4 unlatched write");

      // mode write and masks
      cmd(8'h60); dwr(8'h00, 0, 0, "R3 mode write");
      cmd(8'h20);
      chk("R10 irq_kbd off by mode", irq_kbd, 1'b0);
      rd(8'h00, "R3 mode readback");
      cmd(8'h60); dwr(8'h03, 0, 0, "R3 mode restore");

      cmd(8'hAD);
      @(posedge clk); #2; kbd_in_valid = 1; kbd_in_data = 8'h2A;
      @(posedge clk); #2; kbd_in_valid = 0;
      chk("R6 irq_kbd gated by disable", irq_kbd, 1'b0);
      cmd(8'hAE);
      chk("R6 irq_kbd after enable", irq_kbd, 1'b1);
      rd(8'h2A, "R6 kbd byte");
      cmd(8'hA7); cmd(8'h20); rd(8'h23, "R6 aux disable bit");
      cmd(8'hA8); cmd(8'h20); rd(8'h03, "R6 aux enable bit");

      // replies
      cmd(8'hAA);
      status_is(8'h1D, "R5 self-test flag");
      rd(8'h55, "R5 self-test reply");
      cmd(8'hA9); rd(8'h00, "R5 aux test reply");
      cmd(8'hAB); rd(8'h00, "R5 kbd test reply");
      cmd(8'hC0); rd(8'h80, "R5 input port reply");

      // pulse family
      cmd(8'hFE);
      chk("R7 pulse on FE", sys_reset_req, 1'b1);
      @(posedge clk); #2;
      chk("R7 pulse one cycle", sys_reset_req, 1'b0);
      cmd(8'hF4);
      chk("R7 pulse on F4", sys_reset_req, 1'b1);
      cmd(8'hF1);
      chk("R7 no pulse on F1", sys_reset_req, 1'b0);
      cmd(8'hF3);
      chk("R7 no pulse on F3", sys_reset_req, 1'b0);

      // A20
      cmd(8'hDD);
      chk("R8 gate low", a20_gate, 1'b0);
      cmd(8'hD0); rd(8'hCD, "R8 outport bit1 cleared");
      cmd(8'hDF);
      chk("R8 gate high", a20_gate, 1'b1);
      cmd(8'hD0); rd(8'hCF, "R8 outport bit1 set");

      // output port write
      cmd(8'hD1); dwr(8'hCC, 0, 0, "R9 outport write");
      chk("R9 a20 from byte", a20_gate, 1'b0);
      chk("R9 reset pulse", sys_reset_req, 1'b1);
      cmd(8'hD1); dwr(8'hCF, 0, 0, "R9 outport restore");
      chk("R9 a20 restored", a20_gate, 1'b1);
      chk("R9 no pulse with bit0 set", sys_reset_req, 1'b0);
      cmd(8'hD0); rd(8'hCF, "R9 outport readback");

      // unknown code
      cmd(8'h55);
      cmd(8'h20); rd(8'h03, "R13 mode unchanged");
      cmd(8'hD0); rd(8'hCF, "R13 outport unchanged");
      dwr(8'h5A, 1, 0, "R13 no latch armed");
      cmd(8'hD2); cmd(8'h55); dwr(8'h66, 0, 0, "R13 latch kept");
      rd(8'h66, "R13 latched byte");

      // internal load beats device byte
      @(posedge clk); #2;
      kbd_in_valid = 1; kbd_in_data = 8'h11;
      host_wr = 1; host_sel = 1; host_wdata = 8'hC0;
      #1 chk("R12 ready low during inject", kbd_in_ready, 1'b0);
      @(posedge clk); #2;
      host_wr = 0; host_rd = 1; host_sel = 0;
      #1 chk("R12 inject byte kept", host_rdata, 8'h80);
      chk("R12 ready low while full", kbd_in_ready, 1'b0);
      @(posedge clk); #2;
      host_rd = 0; host_sel = 1;
      #1 chk("R12 ready after pop", kbd_in_ready, 1'b1);
      @(posedge clk); #2;
      kbd_in_valid = 0;
      rd(8'h11, "R12 device byte after inject");

      repeat (3) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule